// File: doc/BRIEF.md
# I2C Addressed Slave Responder

This block is the target side of a two-wire serial bus. It watches the clock and data lines through a short synchroniser and recognises bus start, repeated start and stop events. After every start it shifts in an address byte and compares the upper seven bits with a programmable own address. On a match it acknowledges the byte, raises its addressed flag and takes the direction from the last address bit. It then either receives bytes and hands them to local logic, or sends bytes supplied by local logic.

The line is open-drain: the block never drives data high. It only asserts `sda_drive_low`, and the pad pulls the wire low while that output is 1. Local logic provides the own address, the byte to send and an acknowledge policy for received bytes. It gets back each received byte with a one-cycle valid pulse, a pulse each time a transmit byte is taken, and the addressed, direction and bus-active flags.

Top module: `i2c_slave_responder`

## Requirements
- R1: `bus_active` goes to 1 after a start condition (data falling while clock is high) and back to 0 after a stop condition (data rising while clock is high). After reset it is 0.
- R2: When the seven address bits (first seven bits after a start, MSB first) equal `own_addr`, the block pulls data low during the ninth clock pulse and sets `addressed` to 1.
- R3: When the address does not match, the block leaves data released on the ninth pulse, clears `addressed`, and ignores every following bit until the next start or stop: no acknowledge, no `rx_valid`.
- R4: With address bit 0 (the eighth bit) equal to 0, each following group of eight bits is assembled MSB first and presented on `rx_byte` with a one-cycle `rx_valid` pulse.
- R5: For each received data byte, the ninth pulse carries an acknowledge (data low) when `tx_nack` is 0 and a not-acknowledge (data released) when `tx_nack` is 1.
- R6: With address bit 0 equal to 1, `read_dir` is 1. After the address acknowledge the block sends `tx_byte`, MSB first, and pulses `tx_load` when it takes that value.
- R7: During a read, an acknowledge from the master (data low on the ninth pulse) makes the block load and send the next `tx_byte`. A not-acknowledge makes it release data for the rest of the transfer.
- R8: A repeated start begins a new address phase. The address and direction are compared again, and `addressed` and `read_dir` follow the new address byte.
- R9: A stop clears `addressed` and returns the block to idle with data released.
- R10: A start that arrives in the middle of a byte drops the partial byte, so no `rx_valid` is produced for it, and starts a new address phase.
- R11: The block changes `sda_drive_low` only while the synchronised clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| own_addr | input | ADDR_W | Address this responder answers to |
| tx_byte | input | DATA_W | Next byte to send during a read |
| tx_nack | input | 1 | 1 = not-acknowledge received bytes |
| sda_drive_low | output | 1 | 1 = pull the data line low |
| rx_byte | output | DATA_W | Last received data byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is updated |
| tx_load | output | 1 | One-cycle pulse when `tx_byte` is taken |
| addressed | output | 1 | Last address phase matched |
| read_dir | output | 1 | Current transfer is a read by the master |
| bus_active | output | 1 | A start has been seen and no stop yet |

## Verification
A wrong bit count or state shows up as a misplaced acknowledge or data bit on the wire within one nine-pulse byte frame. It also shows as an `rx_valid` pulse that is missing, extra or carries the wrong value, at the eighth rising clock of the affected byte. A stale addressed or direction flag becomes visible at the first acknowledge after a repeated start or stop. Drive changes during a high clock would corrupt bus conditions, and they are caught at the cycle where they happen.

// File: rtl/i2c_resp_pkg.sv
package i2c_resp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_MACK,
    ST_MRES,
    ST_WAIT
  } resp_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= '1;
    else     ff <= {ff[STAGES-2:0], din};
  end

  assign dout = ff[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_resp_fsm.sv
module i2c_resp_fsm
  import i2c_resp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_nack,
  output logic              drive_low,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              tx_load,
  output logic              addressed,
  output logic              read_dir,
  output logic              bus_active
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  resp_state_t       state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] shin;
  logic              ack_on;

  assign shin = {sh[DATA_W-2:0], sda_s};

  always_ff @(posedge clk) begin
    rx_valid <= 1'b0;
    tx_load  <= 1'b0;
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      ack_on     <= 1'b0;
      drive_low  <= 1'b0;
      rx_byte    <= '0;
      addressed  <= 1'b0;
      read_dir   <= 1'b0;
      bus_active <= 1'b0;
    end else if (stop_evt) begin
      state      <= ST_IDLE;
      drive_low  <= 1'b0;
      addressed  <= 1'b0;
      read_dir   <= 1'b0;
      bus_active <= 1'b0;
      ack_on     <= 1'b0;
    end else if (start_evt) begin
      state      <= ST_ADDR;
      cnt        <= '0;
      drive_low  <= 1'b0;
      bus_active <= 1'b1;
      ack_on     <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: if (scl_rise) begin
          sh <= shin;
          if (cnt == LAST) begin
            cnt <= '0;
            if (shin[DATA_W-1 -: ADDR_W] == own_addr) begin
              addressed <= 1'b1;
              read_dir  <= shin[0];
              state     <= ST_AACK;
            end else begin
              addressed <= 1'b0;
              read_dir  <= 1'b0;
              state     <= ST_WAIT;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_AACK: if (scl_fall) begin
          if (!ack_on) begin
            drive_low <= 1'b1;
            ack_on    <= 1'b1;
          end else begin
            ack_on <= 1'b0;
            cnt    <= '0;
            if (read_dir) begin
              sh        <= tx_byte;
              drive_low <= ~tx_byte[DATA_W-1];
              tx_load   <= 1'b1;
              state     <= ST_TX;
            end else begin
              drive_low <= 1'b0;
              state     <= ST_RX;
            end
          end
        end
        ST_RX: if (scl_rise) begin
          sh <= shin;
          if (cnt == LAST) begin
            cnt      <= '0;
            rx_byte  <= shin;
            rx_valid <= 1'b1;
            state    <= ST_RACK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RACK: if (scl_fall) begin
          if (!ack_on) begin
            drive_low <= ~tx_nack;
            ack_on    <= 1'b1;
          end else begin
            drive_low <= 1'b0;
            ack_on    <= 1'b0;
            state     <= ST_RX;
          end
        end
        ST_TX: if (scl_fall) begin
          if (cnt == LAST) begin
            cnt       <= '0;
            drive_low <= 1'b0;
            state     <= ST_MACK;
          end else begin
            sh        <= {sh[DATA_W-2:0], 1'b0};
            drive_low <= ~sh[DATA_W-2];
            cnt       <= cnt + 1'b1;
          end
        end
        ST_MACK: if (scl_rise) begin
          state <= sda_s ? ST_WAIT : ST_MRES;
        end
        ST_MRES: if (scl_fall) begin
          sh        <= tx_byte;
          drive_low <= ~tx_byte[DATA_W-1];
          tx_load   <= 1'b1;
          cnt       <= '0;
          state     <= ST_TX;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_slave_responder.sv
module i2c_slave_responder #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_nack,
  output logic              sda_drive_low,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              tx_load,
  output logic              addressed,
  output logic              read_dir,
  output logic              bus_active
);
  logic [1:0] raw_in, sync_out;
  logic scl_sync, sda_sync;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  assign raw_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[g]),
      .dout (sync_out[g])
    );
  end

  assign scl_sync = sync_out[0];
  assign sda_sync = sync_out[1];

  i2c_bus_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_sync),
    .sda_s     (sda_sync),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_resp_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sda_s      (sda_sync),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .own_addr   (own_addr),
    .tx_byte    (tx_byte),
    .tx_nack    (tx_nack),
    .drive_low  (sda_drive_low),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .tx_load    (tx_load),
    .addressed  (addressed),
    .read_dir   (read_dir),
    .bus_active (bus_active)
  );
endmodule

// File: rtl/i2c_resp_checker.sv
module i2c_resp_checker (
  input logic clk,
  input logic rst,
  input logic scl_sync,
  input logic sda_drive_low,
  input logic rx_valid,
  input logic tx_load,
  input logic addressed,
  input logic read_dir,
  input logic bus_active
);
  p_idle_no_drive_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_active |-> !sda_drive_low);

  p_drive_needs_match_r3: assert property (@(posedge clk) disable iff (rst)
    sda_drive_low |-> addressed);

  p_rx_only_write_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (addressed && !read_dir));

  p_rx_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_load_only_read_r6: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> (addressed && read_dir));

  p_stop_clears_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_active) |-> (!addressed && !sda_drive_low));

  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drive_low) |-> !$past(scl_sync));
endmodule

bind i2c_slave_responder i2c_resp_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .scl_sync      (scl_sync),
  .sda_drive_low (sda_drive_low),
  .rx_valid      (rx_valid),
  .tx_load       (tx_load),
  .addressed     (addressed),
  .read_dir      (read_dir),
  .bus_active    (bus_active)
);

// File: tb/sim_i2c_slave_responder.sv
module sim_i2c_slave_responder;
  localparam int Q = 6;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_bus;
  logic [6:0] own_addr = OWN;
  logic [7:0] tx_byte = 8'h00;
  logic tx_nack = 1'b0;
  logic sda_drive_low, rx_valid, tx_load, addressed, read_dir, bus_active;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0, r11_bad = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  assign sda_bus = m_sda & ~sda_drive_low;

  i2c_slave_responder u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
    .own_addr(own_addr), .tx_byte(tx_byte), .tx_nack(tx_nack),
    .sda_drive_low(sda_drive_low), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .tx_load(tx_load), .addressed(addressed), .read_dir(read_dir),
    .bus_active(bus_active)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard for received bytes, R11 watch
  logic prev_scl = 1'b1, prev_drv = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3/R10: actual unexpected rx_valid byte %0h expected none", rx_byte);
        end else begin
          chk("R4 received byte", rx_byte, exp_q.pop_front());
        end
      end
      if (m_scl && prev_scl && (sda_drive_low != prev_drv)) r11_bad++;
    end
    prev_scl <= m_scl;
    prev_drv <= sda_drive_low;
  end

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic start_c();
    m_sda = 1'b1; m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic rstart_c();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic write_bit(input logic b);
    m_sda = b; wq(Q);
    m_scl = 1'b1; wq(2*Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic read_bit(output logic b);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    b = sda_bus; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) write_bit(v[i]);
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin read_bit(b); v[i] = b; end
  endtask

  // driver: send a data byte expected at the scoreboard, check the ack bit
  task automatic drive_data(input logic [7:0] v, input logic exp_ack_bit, input string req);
    logic a;
    exp_q.push_back(v);
    send_byte(v);
    read_bit(a);
    chk(req, a, exp_ack_bit);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic a;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wq(4);
    chk("R1 reset bus_active", bus_active, 0);
    chk("R9 reset addressed", addressed, 0);
    chk("R11 reset drive", sda_drive_low, 0);

    // Write transfer to own address
    start_c();
    chk("R1 busy after start", bus_active, 1);
    send_byte({OWN, 1'b0});
    read_bit(a);
    chk("R2 address ack", a, 0);
    chk("R2 addressed flag", addressed, 1);
    chk("R4 write direction", read_dir, 0);
    drive_data(8'hA5, 1'b0, "R5 ack with tx_nack=0");
    drive_data(8'h3C, 1'b0, "R5 ack second byte");
    tx_nack = 1'b1;
    drive_data(8'hFF, 1'b1, "R5 nack with tx_nack=1");
    tx_nack = 1'b0;
    stop_c();
    chk("R9 addressed cleared", addressed, 0);
    chk("R1 idle after stop", bus_active, 0);
    chk("R4 scoreboard drained", exp_q.size(), 0);

    // Mismatched address: everything ignored
    start_c();
    send_byte({7'h11, 1'b0});
    read_bit(a);
    chk("R3 no ack on mismatch", a, 1);
    chk("R3 addressed low", addressed, 0);
    send_byte(8'h77);
    read_bit(a);
    chk("R3 data ignored", a, 1);
    stop_c();

    // Read transfer
    tx_byte = 8'hC3;
    start_c();
    send_byte({OWN, 1'b1});
    read_bit(a);
    chk("R2 read address ack", a, 0);
    chk("R6 read direction", read_dir, 1);
    read_byte(v);
    chk("R6 first transmit byte", v, 8'hC3);
    tx_byte = 8'h96;
    write_bit(1'b0);
    read_byte(v);
    chk("R7 next byte after master ack", v, 8'h96);
    write_bit(1'b1);
    read_byte(v);
    chk("R7 released after master nack", v, 8'hFF);
    stop_c();
    chk("R9 idle after read", addressed, 0);

    // Repeated start: write then read, then mismatch
    start_c();
    send_byte({OWN, 1'b0});
    read_bit(a);
    chk("R2 ack before rstart", a, 0);
    drive_data(8'h12, 1'b0, "R4 byte before rstart");
    tx_byte = 8'h5E;
    rstart_c();
    send_byte({OWN, 1'b1});
    read_bit(a);
    chk("R8 ack after rstart", a, 0);
    chk("R8 direction flipped", read_dir, 1);
    chk("R8 still addressed", addressed, 1);
    read_byte(v);
    chk("R8 read after rstart", v, 8'h5E);
    write_bit(1'b1);
    rstart_c();
    send_byte({7'h22, 1'b0});
    read_bit(a);
    chk("R8 no ack on new mismatch", a, 1);
    chk("R8 addressed cleared", addressed, 0);
    stop_c();

    // Abort partial byte with a start
    start_c();
    send_byte({OWN, 1'b0});
    read_bit(a);
    chk("R2 ack before abort", a, 0);
    write_bit(1'b1); write_bit(1'b0); write_bit(1'b1); write_bit(1'b1);
    rstart_c();
    send_byte({OWN, 1'b0});
    read_bit(a);
    chk("R10 ack after abort", a, 0);
    drive_data(8'h81, 1'b0, "R10 byte after abort");
    stop_c();
    wq(4);
    chk("R10 scoreboard drained", exp_q.size(), 0);
    chk("R11 drive stable while SCL high", r11_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule